// File: doc/BRIEF.md
# Register Remap Key-Value Table

This block turns a small set of software-written key-value entries into two per-register lookup tables, one for the integer register file and one for the floating-point register file. Each entry names an architectural register (the key) and says how instructions that refer to it should be reinterpreted. It gives a physical start register, an element width code, a vector flag, a packed-SIMD flag and a bank bit. A type bit in every entry chooses which of the two tables it fills. Several keys may point at overlapping physical registers.

Instruction decode presents a 5-bit architectural register number and a table select on each lookup port. It receives the translated fields combinationally. A register without an enabled slot passes through unchanged as a scalar of default width. Every configuration write starts a sequential rebuild. The rebuild first clears both tables, then walks the entries in ascending index order and fills them in. While it runs, `busy` is high and lookup results are not meaningful. All pins here are plain control or lookup pins with no handshake. A configuration write is accepted in any cycle, and a write during a rebuild restarts it.

Top module: `remap_table`

## Requirements
- R1: After reset `busy` is low and every slot of both tables is disabled, so every lookup misses.
- R2: A write with `cfg_we` high stores `cfg_wdata` into entry `cfg_idx`. The entry format is: key in bits 4:0, target register in bits 9:5, width code in bits 11:10, vector flag in bit 12, packed flag in bit 13, bank in bit 14, type in bit 15 (0 integer, 1 FP) and live in bit 16. `busy` is high from the cycle after the write for NUM_ENTRIES+1 cycles. A write during a rebuild restarts that count.
- R3: A lookup of a disabled slot returns `lk_hit`=0, the target equal to the requested register, width code 0, and vector, packed and bank all 0.
- R4: The type bit steers an entry only into its own table. An integer entry never changes an FP lookup of the same register number, and an FP entry never changes an integer lookup.
- R5: A lookup of an enabled slot returns `lk_hit`=1 together with that entry's target, width code, vector flag and packed flag. Width codes are 0 default, 1 half of default, 2 eight bits and 3 sixteen bits.
- R6: Different keys may map to the same target register, and each of them returns it.
- R7: When two live entries share type and key, the entry with the higher index decides the slot, whatever the order in which they were written.
- R8: An entry with bank bit 1 (reserved) or live bit 0 contributes nothing, so its key misses unless another entry enables it.
- R9: Every rebuild starts from cleared tables. Rewriting the only entry for a key as not live removes that mapping.
- R10: Each lookup port translates independently in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Entry write strobe |
| cfg_idx | input | IDX_W (4) | Entry index to write |
| cfg_wdata | input | ENTRY_W (17) | Entry contents, format in R2 |
| busy | output | 1 | Rebuild in progress |
| lk_is_fp | input | NUM_PORTS | Per port: 0 integer table, 1 FP table |
| lk_reg | input | NUM_PORTS*5 | Per port architectural register |
| lk_hit | output | NUM_PORTS | Per port slot enabled |
| lk_tgt | output | NUM_PORTS*5 | Per port physical start register |
| lk_width | output | NUM_PORTS*2 | Per port element width code |
| lk_vec | output | NUM_PORTS | Per port vector flag |
| lk_pk | output | NUM_PORTS | Per port packed-SIMD flag |
| lk_bank | output | NUM_PORTS | Per port bank bit |

## Verification
The assertions assume that `cfg_idx` stays below NUM_ENTRIES on every write. They also assume that lookup results matter only while `busy` is low. The entry-capture and rebuild-length properties rely on the write strobe being sampled cleanly at a clock edge. The stimulus changes inputs only at falling edges and uses only entry indices 0 to 11. It reads lookup ports only after `busy` has fallen, so none of these assumptions is stretched.

// File: rtl/remap_pkg.sv
`timescale 1ns/1ps
package remap_pkg;
  parameter int unsigned REG_IDX_W = 5;
  localparam int unsigned NUM_REGS = 1 << REG_IDX_W;

  typedef enum logic [1:0] {
    EW_DEFAULT = 2'd0,
    EW_HALF    = 2'd1,
    EW_8       = 2'd2,
    EW_16      = 2'd3
  } elw_e;

  // One configuration entry; field positions match the write format.
  typedef struct packed {
    logic                 live;
    logic                 is_fp;
    logic                 bank;
    logic                 pk;
    logic                 vec;
    elw_e                 width;
    logic [REG_IDX_W-1:0] tgt;
    logic [REG_IDX_W-1:0] key;
  } entry_t;

  localparam int unsigned ENTRY_W = $bits(entry_t);

  // One slot of a per-register lookup table.
  typedef struct packed {
    logic                 en;
    logic                 bank;
    logic                 pk;
    logic                 vec;
    elw_e                 width;
    logic [REG_IDX_W-1:0] tgt;
  } slot_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CLEAR = 2'd1,
    ST_APPLY = 2'd2
  } bld_st_e;
endpackage

// File: rtl/remap_cfg_store.sv
`timescale 1ns/1ps
module remap_cfg_store import remap_pkg::*; #(
  parameter int unsigned NUM_ENTRIES = 16,
  localparam int unsigned IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we_i,
  input  logic [IDX_W-1:0]            idx_i,
  input  entry_t                      wdata_i,
  output entry_t [NUM_ENTRIES-1:0]    entries_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      entries_o <= '0;
    end else if (we_i && (32'(idx_i) < NUM_ENTRIES)) begin
      entries_o[idx_i] <= wdata_i;
    end
  end

  // R2
  cfg_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> entries_o[$past(idx_i)] == $past(wdata_i));
endmodule

// File: rtl/remap_builder.sv
`timescale 1ns/1ps
module remap_builder import remap_pkg::*; #(
  parameter int unsigned NUM_ENTRIES = 16,
  localparam int unsigned CNT_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               start_i,
  input  entry_t [NUM_ENTRIES-1:0]           entries_i,
  output slot_t  [1:0][NUM_REGS-1:0]         tbl_o,
  output logic                               busy_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_ENTRIES - 1);

  bld_st_e          state;
  logic [CNT_W-1:0] cnt;
  entry_t           cur;
  slot_t            cur_slot;

  assign cur = entries_i[cnt];

  always_comb begin
    cur_slot       = '0;
    cur_slot.en    = 1'b1;
    cur_slot.bank  = cur.bank;
    cur_slot.pk    = cur.pk;
    cur_slot.vec   = cur.vec;
    cur_slot.width = cur.width;
    cur_slot.tgt   = cur.tgt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      tbl_o <= '0;
    end else if (start_i) begin
      state <= ST_CLEAR;
      cnt   <= '0;
    end else begin
      case (state)
        ST_CLEAR: begin
          tbl_o <= '0;
          cnt   <= '0;
          state <= ST_APPLY;
        end
        ST_APPLY: begin
          if (cur.live && !cur.bank) begin
            tbl_o[cur.is_fp][cur.key] <= cur_slot;
          end
          if (cnt == LAST) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state != ST_IDLE);

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> busy_o);

  // R2
  rebuild_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> ($past(cnt) == LAST && $past(state) == ST_APPLY));

  // R9
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CLEAR && !start_i) |=> (tbl_o == '0));

  // R2
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(tbl_o));

  for (genvar t = 0; t < 2; t++) begin : g_tbl
    for (genvar s = 0; s < NUM_REGS; s++) begin : g_slot
      // R8
      slot_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_o[t][s].en |-> !tbl_o[t][s].bank);
    end
  end
endmodule

// File: rtl/remap_lookup.sv
`timescale 1ns/1ps
module remap_lookup import remap_pkg::*; (
  input  logic                        clk,
  input  logic                        rst_n,
  input  slot_t [1:0][NUM_REGS-1:0]   tbl_i,
  input  logic                        is_fp_i,
  input  logic [REG_IDX_W-1:0]        reg_i,
  output logic                        hit_o,
  output logic [REG_IDX_W-1:0]        tgt_o,
  output elw_e                        width_o,
  output logic                        vec_o,
  output logic                        pk_o,
  output logic                        bank_o
);
  slot_t sel;

  assign sel = tbl_i[is_fp_i][reg_i];

  always_comb begin
    if (sel.en) begin
      hit_o   = 1'b1;
      tgt_o   = sel.tgt;
      width_o = sel.width;
      vec_o   = sel.vec;
      pk_o    = sel.pk;
      bank_o  = sel.bank;
    end else begin
      hit_o   = 1'b0;
      tgt_o   = reg_i;
      width_o = EW_DEFAULT;
      vec_o   = 1'b0;
      pk_o    = 1'b0;
      bank_o  = 1'b0;
    end
  end

  // R3
  miss_identity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_o |-> (tgt_o == reg_i && width_o == EW_DEFAULT && !vec_o && !pk_o && !bank_o));

  // R8
  hit_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> !bank_o);
endmodule

// File: rtl/remap_table.sv
`timescale 1ns/1ps
module remap_table import remap_pkg::*; #(
  parameter int unsigned NUM_ENTRIES = 16,
  parameter int unsigned NUM_PORTS   = 2,
  localparam int unsigned IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cfg_we,
  input  logic [IDX_W-1:0]                cfg_idx,
  input  logic [ENTRY_W-1:0]              cfg_wdata,
  output logic                            busy,
  input  logic [NUM_PORTS-1:0]            lk_is_fp,
  input  logic [NUM_PORTS*REG_IDX_W-1:0]  lk_reg,
  output logic [NUM_PORTS-1:0]            lk_hit,
  output logic [NUM_PORTS*REG_IDX_W-1:0]  lk_tgt,
  output logic [NUM_PORTS*2-1:0]          lk_width,
  output logic [NUM_PORTS-1:0]            lk_vec,
  output logic [NUM_PORTS-1:0]            lk_pk,
  output logic [NUM_PORTS-1:0]            lk_bank
);
  entry_t [NUM_ENTRIES-1:0]    entries;
  slot_t  [1:0][NUM_REGS-1:0]  tbl;

  remap_cfg_store #(.NUM_ENTRIES(NUM_ENTRIES)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .we_i     (cfg_we),
    .idx_i    (cfg_idx),
    .wdata_i  (entry_t'(cfg_wdata)),
    .entries_o(entries)
  );

  remap_builder #(.NUM_ENTRIES(NUM_ENTRIES)) u_build (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (cfg_we),
    .entries_i(entries),
    .tbl_o    (tbl),
    .busy_o   (busy)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    elw_e w;
    remap_lookup u_look (
      .clk    (clk),
      .rst_n  (rst_n),
      .tbl_i  (tbl),
      .is_fp_i(lk_is_fp[p]),
      .reg_i  (lk_reg[p*REG_IDX_W +: REG_IDX_W]),
      .hit_o  (lk_hit[p]),
      .tgt_o  (lk_tgt[p*REG_IDX_W +: REG_IDX_W]),
      .width_o(w),
      .vec_o  (lk_vec[p]),
      .pk_o   (lk_pk[p]),
      .bank_o (lk_bank[p])
    );
    assign lk_width[p*2 +: 2] = w;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    $past(!rst_n) && !cfg_we |-> !busy || $past(cfg_we));
endmodule

// File: tb/test_remap_table.sv
`timescale 1ns/1ps
module test_remap_table;
  localparam int NP = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic [16:0] cfg_wdata = '0;
  logic        busy;
  logic [NP-1:0]   lk_is_fp = '0;
  logic [NP*5-1:0] lk_reg = '0;
  logic [NP-1:0]   lk_hit, lk_vec, lk_pk, lk_bank;
  logic [NP*5-1:0] lk_tgt;
  logic [NP*2-1:0] lk_width;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  remap_table #(.NUM_ENTRIES(16), .NUM_PORTS(NP)) i_remap_table (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .busy(busy), .lk_is_fp(lk_is_fp), .lk_reg(lk_reg),
    .lk_hit(lk_hit), .lk_tgt(lk_tgt), .lk_width(lk_width), .lk_vec(lk_vec),
    .lk_pk(lk_pk), .lk_bank(lk_bank)
  );

  function automatic logic [16:0] mk(bit live, bit fp, bit bank, bit pk, bit vec,
                                     logic [1:0] w, logic [4:0] tgt, logic [4:0] key);
    return {live, fp, bank, pk, vec, w, tgt, key};
  endfunction

  // Expected lookup word: {hit, tgt, width, vec, pk, bank}
  function automatic logic [10:0] ex(bit hit, logic [4:0] tgt, logic [1:0] w,
                                     bit vec, bit pk);
    return {hit, tgt, w, vec, pk, 1'b0};
  endfunction

  function automatic logic [10:0] miss(logic [4:0] r);
    return {1'b0, r, 2'd0, 1'b0, 1'b0, 1'b0};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(int idx, logic [16:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic look(string tag, int p, bit fp, logic [4:0] r, logic [10:0] exp);
    @(negedge clk);
    lk_is_fp[p] = fp;
    lk_reg[p*5 +: 5] = r;
    #2;
    chk(tag, 32'({lk_hit[p], lk_tgt[p*5 +: 5], lk_width[p*2 +: 2],
                  lk_vec[p], lk_pk[p], lk_bank[p]}), 32'(exp));
  endtask

  task automatic t_reset();
    chk("R1 busy after reset", 32'(busy), 0);
    look("R1 R3 int miss", 0, 1'b0, 5'd7, miss(5'd7));
    look("R1 R3 fp miss", 1, 1'b1, 5'd31, miss(5'd31));
  endtask

  task automatic t_basic();
    int n;
    wr(0, mk(1, 0, 0, 0, 1, 2'd2, 5'd10, 5'd3));
    chk("R2 busy after write", 32'(busy), 1);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk("R2 busy length", 32'(n), 17);
    look("R5 int hit fields", 0, 1'b0, 5'd3, ex(1, 5'd10, 2'd2, 1, 0));
    look("R4 fp untouched", 1, 1'b1, 5'd3, miss(5'd3));
  endtask

  task automatic t_fp_steer();
    wr(1, mk(1, 1, 0, 1, 1, 2'd3, 5'd20, 5'd3));
    wait_idle();
    look("R4 fp hit", 1, 1'b1, 5'd3, ex(1, 5'd20, 2'd3, 1, 1));
    look("R4 int kept", 0, 1'b0, 5'd3, ex(1, 5'd10, 2'd2, 1, 0));
  endtask

  task automatic t_overlap();
    wr(2, mk(1, 0, 0, 0, 1, 2'd1, 5'd10, 5'd4));
    wait_idle();
    look("R6 second key same target", 0, 1'b0, 5'd4, ex(1, 5'd10, 2'd1, 1, 0));
    look("R6 first key same target", 1, 1'b0, 5'd3, ex(1, 5'd10, 2'd2, 1, 0));
  endtask

  task automatic t_dup();
    wr(7, mk(1, 0, 0, 0, 1, 2'd0, 5'd1, 5'd9));
    wait_idle();
    wr(6, mk(1, 0, 0, 0, 0, 2'd3, 5'd2, 5'd9));
    wait_idle();
    look("R7 higher index wins", 0, 1'b0, 5'd9, ex(1, 5'd1, 2'd0, 1, 0));
    wr(5, mk(1, 0, 0, 0, 0, 2'd0, 5'd15, 5'd3));
    wait_idle();
    look("R7 later index overrides", 0, 1'b0, 5'd3, ex(1, 5'd15, 2'd0, 0, 0));
  endtask

  task automatic t_bank_live();
    wr(8, mk(1, 0, 1, 0, 1, 2'd2, 5'd5, 5'd20));
    wait_idle();
    look("R8 reserved bank ignored", 0, 1'b0, 5'd20, miss(5'd20));
    wr(9, mk(0, 0, 0, 0, 1, 2'd2, 5'd6, 5'd21));
    wait_idle();
    look("R8 non-live ignored", 0, 1'b0, 5'd21, miss(5'd21));
  endtask

  task automatic t_remove();
    wr(1, '0);
    wait_idle();
    look("R9 fp mapping removed", 1, 1'b1, 5'd3, miss(5'd3));
    look("R9 int mapping kept", 0, 1'b0, 5'd3, ex(1, 5'd15, 2'd0, 0, 0));
  endtask

  task automatic t_restart();
    int n;
    wr(10, mk(1, 0, 0, 1, 0, 2'd1, 5'd26, 5'd25));
    repeat (4) @(negedge clk);
    wr(11, mk(1, 1, 0, 0, 1, 2'd3, 5'd27, 5'd25));
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk("R2 restart length", 32'(n), 17);
  endtask

  task automatic t_ports();
    @(negedge clk);
    lk_is_fp = 2'b10;
    lk_reg = {5'd25, 5'd25};
    #2;
    chk("R10 port0 int", 32'({lk_hit[0], lk_tgt[4:0], lk_width[1:0], lk_vec[0], lk_pk[0], lk_bank[0]}),
        32'(ex(1, 5'd26, 2'd1, 0, 1)));
    chk("R10 port1 fp", 32'({lk_hit[1], lk_tgt[9:5], lk_width[3:2], lk_vec[1], lk_pk[1], lk_bank[1]}),
        32'(ex(1, 5'd27, 2'd3, 1, 0)));
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_fp_steer();
    t_overlap();
    t_dup();
    t_bank_live();
    t_remove();
    t_restart();
    t_ports();
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end
endmodule